// File: doc/BRIEF.md
# Rate-1/3 Turbo Encoder

This block turns a serial stream of information bits into a rate-1/3 turbo code for fixed blocks of 192 bits. The bits of one block are first collected in on-chip storage. Once the block is complete, two identical recursive systematic convolutional encoders run side by side. The first encoder takes the bits in arrival order. The second takes them in a scrambled order that a quadratic permutation defines. For each information bit the block emits a triple: the systematic bit, the first encoder's parity and the second encoder's parity.

After the 192 data triples, each encoder is returned to the all-zero state by three extra input bits. The first encoder is flushed first, then the second. These tail triples close the block, so each block produces 198 valid triples. While a block is being encoded, the input side is closed. It reopens in the cycle that presents the final tail triple.

Top module: `te_turbo_enc`

## Requirements
- R1: An input bit is taken only in a cycle where `in_valid` and `in_ready` are both 1. A bit taken with `in_sob` = 0 while no block is open is discarded and has no effect on any later output.
- R2: A bit taken with `in_sob` = 1 always becomes index 0 of a new block. Any partly collected block is abandoned.
- R3: `in_ready` falls in the cycle after the 192nd bit of a block is taken. It stays 0 until the last tail triple is presented, and rises in that same cycle.
- R4: Each block yields exactly 198 cycles with `out_valid` = 1, and these cycles are consecutive. In the first 192 triples, `out_sys` equals the input bits in arrival order.
- R5: For data triple i, `out_par1` is the parity of a recursive code with three memory cells, cleared at block start. The feedback polynomial is 1+D^2+D^3 (octal 13) and the feedforward polynomial is 1+D+D^3 (octal 15). The code's input is input bit i.
- R6: For data triple i, `out_par2` is the parity of the same code, also cleared at block start. Its input is the bit at index pi(i) = (23*i + 48*i*i) mod 192.
- R7: Tail triples 193 to 195 carry the first encoder's flush. `out_sys` is its feedback value (the XOR of its 2nd and 3rd memory cells), `out_par1` is its parity and `out_par2` is 0. Tail triples 196 to 198 carry the second encoder's flush in the same way, with `out_par1` = 0 and the parity on `out_par2`. After the flush, both encoders hold the zero state.
- R8: After reset, `in_ready` is 1 and `out_valid` is 0.
- R9: Input activity while `in_ready` is 0, including `in_sob` pulses, does not change the triples of the block being encoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bit present |
| in_sob | input | 1 | Marks the first bit of a block |
| in_bit | input | 1 | Information bit |
| in_ready | output | 1 | Block collection open |
| out_valid | output | 1 | Output triple present |
| out_sys | output | 1 | Systematic or tail bit |
| out_par1 | output | 1 | Parity of the natural-order encoder |
| out_par2 | output | 1 | Parity of the interleaved-order encoder |

## Verification
The assertions assume that a block is always opened by a start-of-block bit, and that the downstream side accepts every triple as it is presented, since the output has no backpressure. The stimulus raises `in_sob` only on the first bit of each block. The exceptions are the deliberate stray bits before a block, the abandoned partial block and the input noise driven while encoding is under way. In every case the bench keeps `in_valid` low on the clock edge where `in_ready` comes back, unless it really means to start the next block.

// File: rtl/te_pkg.sv
package te_pkg;

  // Sequencer phases of the encoder
  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,
    ST_RUN   = 2'd1,
    ST_TAIL1 = 2'd2,
    ST_TAIL2 = 2'd3
  } te_state_e;

endpackage

// File: rtl/te_bit_ram.sv
// Single-bit-wide simple dual-port storage with registered read, BRAM style.
module te_bit_ram #(
  parameter int DEPTH = 192,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);

  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  p_waddr_range_r1: assert property (@(posedge clk) we |-> (waddr < AW'(DEPTH)))
    else $error("write address beyond block");

endmodule

// File: rtl/te_qpp_addr.sv
// Quadratic permutation address, produced by two running sums (no multiplier).
// pi(i+1) = pi(i) + g(i), g(i+1) = g(i) + 2*F2, all mod N.
module te_qpp_addr #(
  parameter int N  = 192,
  parameter int F1 = 23,
  parameter int F2 = 48,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          adv,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] G_INIT = AW'((F1 + F2) % N);
  localparam logic [AW-1:0] G_STEP = AW'((2 * F2) % N);

  logic [AW-1:0] pi_q, g_q;

  function automatic logic [AW-1:0] add_mod(input logic [AW-1:0] a, input logic [AW-1:0] b);
    logic [AW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= (AW+1)'(N)) s = s - (AW+1)'(N);
    return s[AW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst || start) begin
      pi_q <= '0;
      g_q  <= G_INIT;
    end else if (adv) begin
      pi_q <= add_mod(pi_q, g_q);
      g_q  <= add_mod(g_q, G_STEP);
    end
  end

  assign addr = pi_q;

  p_addr_range_r6: assert property (@(posedge clk) disable iff (rst) adv |-> (pi_q < AW'(N)))
    else $error("interleaver address out of range");

endmodule

// File: rtl/te_rsc.sv
// Recursive systematic convolutional constituent encoder.
// Polynomial bit CONSTR_LEN-1 is the D^0 term; bit CONSTR_LEN-1-k is D^k.
module te_rsc #(
  parameter int CONSTR_LEN = 4,
  parameter logic [CONSTR_LEN-1:0] FB_POLY = 4'b1011,
  parameter logic [CONSTR_LEN-1:0] FF_POLY = 4'b1101,
  localparam int MEM = CONSTR_LEN - 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           step,
  input  logic           tail,
  input  logic           din,
  output logic           par,
  output logic           u_used,
  output logic [MEM-1:0] st_o
);

  logic [MEM-1:0] st_q;
  logic           fb_sum, a;

  always_comb begin
    fb_sum = 1'b0;
    for (int k = 1; k <= MEM; k++) begin
      if (FB_POLY[MEM-k]) fb_sum = fb_sum ^ st_q[k-1];
    end
    u_used = tail ? fb_sum : din;
    a      = u_used ^ fb_sum;
    par    = FF_POLY[MEM] & a;
    for (int k = 1; k <= MEM; k++) begin
      if (FF_POLY[MEM-k]) par = par ^ st_q[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) st_q <= '0;
    else if (step)  st_q <= {st_q[MEM-2:0], a};
  end

  assign st_o = st_q;

endmodule

// File: rtl/te_turbo_enc.sv
module te_turbo_enc
  import te_pkg::*;
#(
  parameter int BLK_LEN    = 192,
  parameter int INTL_F1    = 23,
  parameter int INTL_F2    = 48,
  parameter int CONSTR_LEN = 4,
  parameter logic [CONSTR_LEN-1:0] FB_POLY = 4'b1011,
  parameter logic [CONSTR_LEN-1:0] FF_POLY = 4'b1101
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_sob,
  input  logic in_bit,
  output logic in_ready,
  output logic out_valid,
  output logic out_sys,
  output logic out_par1,
  output logic out_par2
);

  localparam int AW    = $clog2(BLK_LEN);
  localparam int MEM   = CONSTR_LEN - 1;
  localparam int TW    = (MEM > 1) ? $clog2(MEM) : 1;
  localparam int TOTAL = BLK_LEN + 2 * MEM;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam logic [AW-1:0] LAST_A = AW'(BLK_LEN - 1);
  localparam logic [TW-1:0] TLAST  = TW'(MEM - 1);

  te_state_e     state_q;
  logic [AW:0]   wr_cnt_q;
  logic [AW-1:0] rd_idx_q;
  logic          issued_all_q, rd_vld_q, rd_last_q;
  logic [TW-1:0] tcnt_q;

  logic          accept, wr_en, blk_full, rd_go;
  logic [AW-1:0] wr_addr, intl_addr;
  logic [AW-1:0] rd_addr [2];
  logic          rd_data [2];

  assign in_ready = (state_q == ST_FILL);
  assign accept   = in_valid && in_ready;
  assign wr_en    = accept && (in_sob || (wr_cnt_q != '0));
  assign wr_addr  = in_sob ? '0 : wr_cnt_q[AW-1:0];
  assign blk_full = wr_en && (wr_addr == LAST_A);
  assign rd_go    = (state_q == ST_RUN) && !issued_all_q;

  // Block store: one copy per read order so each gets its own read port
  assign rd_addr[0] = rd_idx_q;
  assign rd_addr[1] = intl_addr;

  for (genvar c = 0; c < 2; c++) begin : g_store
    te_bit_ram #(.DEPTH(BLK_LEN), .AW(AW)) u_ram (
      .clk  (clk),
      .we   (wr_en),
      .waddr(wr_addr),
      .wdata(in_bit),
      .re   (rd_go),
      .raddr(rd_addr[c]),
      .rdata(rd_data[c])
    );
  end

  te_qpp_addr #(.N(BLK_LEN), .F1(INTL_F1), .F2(INTL_F2), .AW(AW)) u_qpp (
    .clk  (clk),
    .rst  (rst),
    .start(blk_full),
    .adv  (rd_go),
    .addr (intl_addr)
  );

  // Sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_FILL;
      wr_cnt_q     <= '0;
      rd_idx_q     <= '0;
      issued_all_q <= 1'b0;
      rd_vld_q     <= 1'b0;
      rd_last_q    <= 1'b0;
      tcnt_q       <= '0;
    end else begin
      rd_vld_q  <= rd_go;
      rd_last_q <= rd_go && (rd_idx_q == LAST_A);
      unique case (state_q)
        ST_FILL: begin
          if (wr_en) wr_cnt_q <= {1'b0, wr_addr} + 1'b1;
          if (blk_full) begin
            state_q      <= ST_RUN;
            wr_cnt_q     <= '0;
            rd_idx_q     <= '0;
            issued_all_q <= 1'b0;
          end
        end
        ST_RUN: begin
          if (rd_go) begin
            rd_idx_q <= rd_idx_q + 1'b1;
            if (rd_idx_q == LAST_A) issued_all_q <= 1'b1;
          end
          if (rd_vld_q && rd_last_q) begin
            state_q <= ST_TAIL1;
            tcnt_q  <= '0;
          end
        end
        ST_TAIL1: begin
          if (tcnt_q == TLAST) begin
            state_q <= ST_TAIL2;
            tcnt_q  <= '0;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_TAIL2: begin
          if (tcnt_q == TLAST) begin
            state_q <= ST_FILL;
            tcnt_q  <= '0;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        default: state_q <= ST_FILL;
      endcase
    end
  end

  // Constituent encoders
  logic           step1, step2, tail1, tail2;
  logic           par1, par2, u1, u2;
  logic [MEM-1:0] st1, st2;

  assign tail1 = (state_q == ST_TAIL1);
  assign tail2 = (state_q == ST_TAIL2);
  assign step1 = rd_vld_q || tail1;
  assign step2 = rd_vld_q || tail2;

  te_rsc #(.CONSTR_LEN(CONSTR_LEN), .FB_POLY(FB_POLY), .FF_POLY(FF_POLY)) u_enc1 (
    .clk(clk), .rst(rst), .clr(blk_full), .step(step1), .tail(tail1),
    .din(rd_data[0]), .par(par1), .u_used(u1), .st_o(st1)
  );

  te_rsc #(.CONSTR_LEN(CONSTR_LEN), .FB_POLY(FB_POLY), .FF_POLY(FF_POLY)) u_enc2 (
    .clk(clk), .rst(rst), .clr(blk_full), .step(step2), .tail(tail2),
    .din(rd_data[1]), .par(par2), .u_used(u2), .st_o(st2)
  );

  // Registered output triple
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sys   <= 1'b0;
      out_par1  <= 1'b0;
      out_par2  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (rd_vld_q) begin
        out_valid <= 1'b1;
        out_sys   <= rd_data[0];
        out_par1  <= par1;
        out_par2  <= par2;
      end else if (tail1) begin
        out_valid <= 1'b1;
        out_sys   <= u1;
        out_par1  <= par1;
        out_par2  <= 1'b0;
      end else if (tail2) begin
        out_valid <= 1'b1;
        out_sys   <= u2;
        out_par1  <= 1'b0;
        out_par2  <= par2;
      end
    end
  end

  // Assertion support: triples presented in the current block
  logic [CW-1:0] out_cnt_q;
  always_ff @(posedge clk) begin
    if (rst) out_cnt_q <= '0;
    else if (out_valid) out_cnt_q <= in_ready ? '0 : out_cnt_q + 1'b1;
  end

  p_ready_drop_r3: assert property (@(posedge clk) disable iff (rst)
    blk_full |=> !in_ready)
    else $error("ready still high after a full block");

  p_idle_after_last_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && in_ready) |=> !out_valid)
    else $error("output continues after the last tail triple");

  p_contiguous_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !in_ready) |=> out_valid)
    else $error("gap inside an output block");

  p_block_len_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && in_ready) |-> (out_cnt_q == CW'(TOTAL - 1)))
    else $error("wrong number of triples in a block");

  p_enc1_flushed_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TAIL2 && $past(state_q) == ST_TAIL1) |-> (st1 == '0))
    else $error("first encoder not at zero after its tail");

  p_enc2_flushed_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FILL && $past(state_q) == ST_TAIL2) |-> (st2 == '0))
    else $error("second encoder not at zero after its tail");

  p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_FILL) |-> !wr_en)
    else $error("storage written while encoding");

endmodule

// File: tb/te_turbo_enc_test.sv
module te_turbo_enc_test;

  localparam int BLK   = 192;
  localparam int TOTAL = BLK + 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sob = 1'b0, in_bit = 1'b0;
  logic in_ready, out_valid, out_sys, out_par1, out_par2;

  int nchk = 0;
  int nfail = 0;

  bit exp_s [TOTAL];
  bit exp_p1[TOTAL];
  bit exp_p2[TOTAL];

  always #10 clk = ~clk;

  te_turbo_enc uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sob(in_sob), .in_bit(in_bit),
    .in_ready(in_ready), .out_valid(out_valid), .out_sys(out_sys),
    .out_par1(out_par1), .out_par2(out_par2)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural model of the whole code, from the requirements
  task automatic build_expect(input logic [BLK-1:0] b);
    bit r1, r2, r3, a, u;
    int pi;
    r1 = 0; r2 = 0; r3 = 0;
    for (int i = 0; i < BLK; i++) begin
      u = b[i]; a = u ^ r2 ^ r3;
      exp_s[i] = u; exp_p1[i] = a ^ r1 ^ r3;
      r3 = r2; r2 = r1; r1 = a;
    end
    for (int t = 0; t < 3; t++) begin
      u = r2 ^ r3;
      exp_s[BLK+t] = u; exp_p1[BLK+t] = r1 ^ r3; exp_p2[BLK+t] = 0;
      r3 = r2; r2 = r1; r1 = 0;
    end
    r1 = 0; r2 = 0; r3 = 0;
    for (int i = 0; i < BLK; i++) begin
      pi = (23 * i + 48 * i * i) % BLK;
      u = b[pi]; a = u ^ r2 ^ r3;
      exp_p2[i] = a ^ r1 ^ r3;
      r3 = r2; r2 = r1; r1 = a;
    end
    for (int t = 0; t < 3; t++) begin
      u = r2 ^ r3;
      exp_s[BLK+3+t] = u; exp_p1[BLK+3+t] = 0; exp_p2[BLK+3+t] = r1 ^ r3;
      r3 = r2; r2 = r1; r1 = 0;
    end
  endtask

  task automatic feed(input logic [BLK-1:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sob = (i == 0); in_bit = b[i];
    end
    @(negedge clk);
    if (n == BLK) chk(in_ready == 1'b0, "R3", "ready after full block", in_ready, 0);
    in_valid = 1'b0; in_sob = 1'b0; in_bit = 1'b0;
  endtask

  // Feeds a whole block, collects its triples and compares them with the model
  task automatic run_block(input logic [BLK-1:0] b, input bit busy_noise, input string name);
    bit gs[TOTAL], g1[TOTAL], g2[TOTAL];
    int n = 0;
    bit gap = 0, early_ready = 0, done = 0;
    build_expect(b);
    feed(b, BLK);
    for (int cyc = 0; cyc < 2000 && !done; cyc++) begin
      @(negedge clk);
      if (out_valid) begin
        gs[n] = out_sys; g1[n] = out_par1; g2[n] = out_par2;
        n++;
      end else if (n > 0) begin
        gap = 1;
      end
      if (n == TOTAL) begin
        chk(in_ready == 1'b1, "R3", {name, " ready with last tail"}, in_ready, 1);
        in_valid = 1'b0; in_sob = 1'b0; in_bit = 1'b0;
        done = 1;
      end else begin
        if (in_ready) early_ready = 1;
        if (busy_noise) begin
          in_valid = 1'b1; in_sob = 1'b1; in_bit = cyc[0];
        end
      end
    end
    chk(done, "R4", {name, " triples collected"}, n, TOTAL);
    chk(!gap, "R4", {name, " triples consecutive"}, gap, 0);
    chk(!early_ready, "R3", {name, " ready low while busy"}, early_ready, 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R4", {name, " no triple after block"}, out_valid, 0);
    for (int j = 0; j < n && j < TOTAL; j++) begin
      if (j < BLK) begin
        chk(gs[j] == exp_s[j], busy_noise ? "R9" : "R4", $sformatf("%s sys[%0d]", name, j), gs[j], exp_s[j]);
        chk(g1[j] == exp_p1[j], "R5", $sformatf("%s par1[%0d]", name, j), g1[j], exp_p1[j]);
        chk(g2[j] == exp_p2[j], "R6", $sformatf("%s par2[%0d]", name, j), g2[j], exp_p2[j]);
      end else begin
        chk(gs[j] == exp_s[j], "R7", $sformatf("%s tail sys[%0d]", name, j), gs[j], exp_s[j]);
        chk(g1[j] == exp_p1[j], "R7", $sformatf("%s tail par1[%0d]", name, j), g1[j], exp_p1[j]);
        chk(g2[j] == exp_p2[j], "R7", $sformatf("%s tail par2[%0d]", name, j), g2[j], exp_p2[j]);
      end
    end
  endtask

  function automatic logic [BLK-1:0] pseudo(input int seed);
    logic [BLK-1:0] v;
    int unsigned x = seed;
    for (int i = 0; i < BLK; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      v[i] = x[7];
    end
    return v;
  endfunction

  task automatic test_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R8", "ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R8", "valid after reset", out_valid, 0);
  endtask

  task automatic test_patterns();
    logic [BLK-1:0] v;
    run_block('0, 0, "zeros");
    run_block('1, 0, "ones");
    v = '0; v[0] = 1'b1;
    run_block(v, 0, "impulse_first");
    v = '0; v[BLK-1] = 1'b1;
    run_block(v, 0, "impulse_last");
    for (int i = 0; i < BLK; i++) v[i] = i[0];
    run_block(v, 0, "alternating");
    run_block(pseudo(32'h1234_5678), 0, "pseudo_a");
  endtask

  task automatic test_stray_bits();
    // R1: bits without an open block are dropped
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sob = 1'b0; in_bit = 1'b1;
    end
    run_block(pseudo(32'h0BAD_F00D), 0, "stray_R1");
  endtask

  task automatic test_restart();
    // R2: a partial block is abandoned when a new start arrives
    feed('1, 50);
    run_block(pseudo(32'h7777_0001), 0, "restart_R2");
  endtask

  task automatic test_busy_noise();
    run_block(pseudo(32'h00C0_FFEE), 1, "noise_R9");
  endtask

  task automatic test_back_to_back();
    run_block(pseudo(32'h1111_2222), 0, "b2b_first");
    run_block(pseudo(32'h3333_4444), 0, "b2b_second");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_patterns();
    test_stray_bits();
    test_restart();
    test_busy_noise();
    test_back_to_back();
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule